// File: doc/BRIEF.md
# Auto-Negotiation Arbiter

This block is the decision core of 10/100 copper auto-negotiation. It receives link code words that a pulse decoder has already turned into 16-bit values, and two flags that report a detected 10 Mb/s idle or 100 Mb/s idle. It holds the local advertisement word. It records the partner's word once that word has arrived consistently. It then picks the best technology that both ends share and reports the resolved speed and duplex.

The ability field of the advertisement is seeded from a 3-bit strap. Software may later remove an ability but can never add one. A negotiation that finds no shared technology, or that runs longer than a cycle budget, sets a failure flag and starts over from the beginning. A restart input begins a fresh negotiation at any time.

Top module: `anar_core`

## Requirements
- R1: On the first clock after reset, ability bits [8:5] of `adv_word` take their value from `strap_tech`. Bit 8 is 100BASE-TX full duplex, bit 7 is 100BASE-TX half duplex, bit 6 is 10BASE-T full duplex and bit 5 is 10BASE-T half duplex. The strap encodings are: 111 gives 1111, 110 gives 1100, 101 gives 0011, 011 gives 0101, 010 gives 0100, 001 gives 0001, and 000 or 100 give 0000. Bits [4:0] hold the SELECTOR parameter (default 00001) and bits [15:9] reset to zero.
- R2: A write of `adv_wr_data` can clear ability bits [8:5] but never set them. The write stores bits [15:9] as given, and bits [4:0] do not change.
- R3: While listening, three consecutive identical received words store the third word in `lp_word`. Bit 14, the acknowledge bit, is ignored in this comparison. A word that differs from the previous one restarts the count at one.
- R4: After the word is stored, three consecutive identical words that all have bit 14 set complete the negotiation. A word with bit 14 clear resets this count to zero.
- R5: Completion selects the highest shared ability in the order 100BASE-TX full, 100BASE-TX half, 10BASE-T full, 10BASE-T half. It sets `an_done` together with `res_speed100` and `res_full`.
- R6: While negotiating, a detected idle completes the negotiation at half duplex. The speed is the speed of that idle, and 100 Mb/s wins if both idles are present.
- R7: If no ability is shared, `an_fail` is set, `an_done` stays low, `lp_word` is cleared and listening starts again.
- R8: If TIMEOUT_CYC clock cycles pass after a (re)start without completion, `an_fail` is set and negotiation starts again.
- R9: `restart` clears `an_done`, `an_fail`, `lp_word` and the results, and begins a new negotiation.
- R10: Once done, the results and `lp_word` hold steady. Received words and idle flags are ignored until `restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_tech | input | 3 | Technology strap that seeds the advertisement |
| adv_wr_en | input | 1 | Advertisement write strobe |
| adv_wr_data | input | 16 | Advertisement write data |
| adv_word | output | 16 | Local advertisement word |
| rx_word_vld | input | 1 | One-cycle strobe for a received link code word |
| rx_word | input | 16 | Received link code word |
| idle10_det | input | 1 | 10 Mb/s idle detected on the line |
| idle100_det | input | 1 | 100 Mb/s idle detected on the line |
| restart | input | 1 | Begin a new negotiation |
| an_done | output | 1 | Negotiation completed |
| an_fail | output | 1 | Last negotiation attempt failed |
| res_speed100 | output | 1 | Resolved speed is 100 Mb/s |
| res_full | output | 1 | Resolved mode is full duplex |
| lp_word | output | 16 | Stored partner word |

## Verification
The hardest state to reach from the ports is a count in progress that is interrupted. Examples are a count that is broken by a differing word, a word whose only difference is the acknowledge bit, or an acknowledge-phase run cut by a word without that bit. The stimulus sends such broken sequences word by word and checks that nothing is stored or resolved one word before the expected completion. It then checks that completion arrives exactly on the third consistent word. Clear-only advertisement writes are reached by a reset with a full strap followed by one reducing write, and the table then pairs each reduced advertisement with a partner ability set.

// File: rtl/anar_pkg.sv
package anar_pkg;
   localparam int ANAR_WORD_W  = 16;
   localparam int ANAR_ACK_BIT = 14;
   localparam int ANAR_ABIL_LO = 5;
   localparam int ANAR_ABIL_N  = 4;

   typedef enum logic [1:0] {
      ST_LISTEN = 2'd0,
      ST_ACK    = 2'd1,
      ST_DONE   = 2'd2
   } an_state_t;

   // ability order, index 3..0: 100 full, 100 half, 10 full, 10 half
   function automatic logic [ANAR_ABIL_N-1:0] strap_to_abil(input logic [2:0] s);
      logic [ANAR_ABIL_N-1:0] a;
      case (s)
         3'b111:  a = 4'b1111;
         3'b110:  a = 4'b1100;
         3'b101:  a = 4'b0011;
         3'b011:  a = 4'b0101;
         3'b010:  a = 4'b0100;
         3'b001:  a = 4'b0001;
         default: a = 4'b0000;
      endcase
      return a;
   endfunction
endpackage

// File: rtl/anar_adv_reg.sv
module anar_adv_reg
   import anar_pkg::*;
#(
   parameter int         W   = ANAR_WORD_W,
   parameter logic [4:0] SEL = 5'b00001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [2:0]   strap,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] adv
);
   localparam int HI_LO = ANAR_ABIL_LO + ANAR_ABIL_N;

   generate
      if (W <= HI_LO) begin : g_bad_width
         $error("anar_adv_reg: word width too small");
      end
   endgenerate

   logic                   seeded;
   logic [ANAR_ABIL_N-1:0] seed_abil;
   logic [ANAR_ABIL_N-1:0] abil;
   logic [W-1:HI_LO]       hi;

   assign seed_abil = strap_to_abil(strap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seeded <= 1'b0;
      else        seeded <= 1'b1;
   end

   // one clear-only cell per ability bit
   for (genvar i = 0; i < ANAR_ABIL_N; i++) begin : g_abil
      logic b;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    b <= 1'b0;
         else if (!seeded)                              b <= seed_abil[i];
         else if (wr_en && !wr_data[ANAR_ABIL_LO + i])  b <= 1'b0;
      end
      assign abil[i] = b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hi <= '0;
      else if (seeded && wr_en)  hi <= wr_data[W-1:HI_LO];
   end

   assign adv = {hi, abil, SEL};
endmodule

// File: rtl/anar_match.sv
module anar_match
   import anar_pkg::*;
#(
   parameter int W    = ANAR_WORD_W,
   parameter int N    = 3,
   parameter int ACKB = ANAR_ACK_BIT
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         vld,
   input  logic [W-1:0] word,
   input  logic         ack_phase,
   output logic         hit
);
   localparam int CW = $clog2(N + 1);

   generate
      if (N < 2) begin : g_bad_n
         $error("anar_match: N must be at least 2");
      end
      if (ACKB >= W) begin : g_bad_ack
         $error("anar_match: acknowledge bit outside word");
      end
   endgenerate

   logic [W-1:0]  prev;
   logic [W-1:0]  mask;
   logic [CW-1:0] cnt;
   logic          eq;
   logic          qual;

   assign mask = ack_phase ? '1 : ~(W'(1) << ACKB);
   assign qual = !ack_phase || word[ACKB];
   assign eq   = ((word ^ prev) & mask) == '0;
   assign hit  = vld && qual && (cnt != '0) && eq && (cnt == CW'(N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         prev <= '0;
      end else if (clr) begin
         cnt  <= '0;
      end else if (vld) begin
         prev <= word;
         if (!qual)                   cnt <= '0;
         else if (cnt != '0 && eq)    cnt <= cnt + 1'b1;
         else                         cnt <= CW'(1);
      end
   end
endmodule

// File: rtl/anar_resolve.sv
module anar_resolve
   import anar_pkg::*;
(
   input  logic [ANAR_ABIL_N-1:0] loc,
   input  logic [ANAR_ABIL_N-1:0] lp,
   output logic                   any,
   output logic                   speed100,
   output logic                   full
);
   logic [ANAR_ABIL_N-1:0] common;

   assign common = loc & lp;
   assign any    = |common;

   // later (higher) index overrides, giving highest priority last
   always_comb begin
      speed100 = 1'b0;
      full     = 1'b0;
      for (int i = 0; i < ANAR_ABIL_N; i++) begin
         if (common[i]) begin
            speed100 = (i >= 2);
            full     = (i % 2) == 1;
         end
      end
   end
endmodule

// File: rtl/anar_core.sv
module anar_core
   import anar_pkg::*;
#(
   parameter int         TIMEOUT_CYC = 4096,
   parameter int         MATCH_CNT   = 3,
   parameter logic [4:0] SELECTOR    = 5'b00001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  strap_tech,
   input  logic        adv_wr_en,
   input  logic [15:0] adv_wr_data,
   output logic [15:0] adv_word,
   input  logic        rx_word_vld,
   input  logic [15:0] rx_word,
   input  logic        idle10_det,
   input  logic        idle100_det,
   input  logic        restart,
   output logic        an_done,
   output logic        an_fail,
   output logic        res_speed100,
   output logic        res_full,
   output logic [15:0] lp_word
);
   localparam int W  = ANAR_WORD_W;
   localparam int TW = $clog2(TIMEOUT_CYC + 1);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("anar_core: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   an_state_t state;
   logic [TW-1:0] timer;
   logic active, wvld, hit, idle_take, timeout;
   logic r_any, r_spd, r_full, clr_match;

   anar_adv_reg #(.W(W), .SEL(SELECTOR)) u_adv (
      .clk(clk), .rst_n(rst_n), .strap(strap_tech),
      .wr_en(adv_wr_en), .wr_data(adv_wr_data), .adv(adv_word));

   assign active    = (state != ST_DONE);
   assign wvld      = rx_word_vld && active;
   assign idle_take = active && (idle10_det || idle100_det);
   assign timeout   = active && (timer == TW'(TIMEOUT_CYC - 1));
   assign clr_match = restart || idle_take || hit || timeout;

   anar_match #(.W(W), .N(MATCH_CNT), .ACKB(ANAR_ACK_BIT)) u_match (
      .clk(clk), .rst_n(rst_n), .clr(clr_match), .vld(wvld),
      .word(rx_word), .ack_phase(state == ST_ACK), .hit(hit));

   anar_resolve u_res (
      .loc(adv_word[ANAR_ABIL_LO +: ANAR_ABIL_N]),
      .lp(lp_word[ANAR_ABIL_LO +: ANAR_ABIL_N]),
      .any(r_any), .speed100(r_spd), .full(r_full));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_LISTEN;
         timer        <= '0;
         lp_word      <= '0;
         an_done      <= 1'b0;
         an_fail      <= 1'b0;
         res_speed100 <= 1'b0;
         res_full     <= 1'b0;
      end else if (restart) begin
         state        <= ST_LISTEN;
         timer        <= '0;
         lp_word      <= '0;
         an_done      <= 1'b0;
         an_fail      <= 1'b0;
         res_speed100 <= 1'b0;
         res_full     <= 1'b0;
      end else if (active) begin
         if (idle_take) begin
            state        <= ST_DONE;
            an_done      <= 1'b1;
            an_fail      <= 1'b0;
            res_speed100 <= idle100_det;
            res_full     <= 1'b0;
         end else if (hit && state == ST_LISTEN) begin
            lp_word <= rx_word;
            state   <= ST_ACK;
            timer   <= timer + 1'b1;
         end else if (hit && r_any) begin
            state        <= ST_DONE;
            an_done      <= 1'b1;
            an_fail      <= 1'b0;
            res_speed100 <= r_spd;
            res_full     <= r_full;
         end else if (hit || timeout) begin
            an_fail <= 1'b1;
            state   <= ST_LISTEN;
            lp_word <= '0;
            timer   <= '0;
         end else begin
            timer <= timer + 1'b1;
         end
      end
   end
endmodule

// File: rtl/anar_checks.sv
module anar_checks (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] adv_word,
   input logic        idle10_det,
   input logic        idle100_det,
   input logic        restart,
   input logic        an_done,
   input logic        an_fail,
   input logic        res_speed100,
   input logic        res_full,
   input logic [15:0] lp_word
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 1'b1;
   end

   p_adv_noset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> ((adv_word[8:5] & ~$past(adv_word[8:5])) == 4'd0));

   p_full_common_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(an_done) && res_full) |->
         (res_speed100 ? ($past(adv_word[8]) && lp_word[8])
                       : ($past(adv_word[6]) && lp_word[6])));

   p_idle_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(an_done) && $past(idle10_det || idle100_det)) |->
         (!res_full && res_speed100 == $past(idle100_det)));

   p_done_fail_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(an_done && an_fail));

   p_restart_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!an_done && !an_fail && lp_word == 16'd0));

   p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (an_done && !restart) |=>
         (an_done && $stable(res_speed100) && $stable(res_full) && $stable(lp_word)));
endmodule

bind anar_core anar_checks u_checks (
   .clk(clk), .rst_n(rst_n), .adv_word(adv_word),
   .idle10_det(idle10_det), .idle100_det(idle100_det), .restart(restart),
   .an_done(an_done), .an_fail(an_fail), .res_speed100(res_speed100),
   .res_full(res_full), .lp_word(lp_word));

// File: tb/anar_core_bench.sv
`timescale 1ns/1ps
module anar_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  strap_tech = 3'b111;
   logic        adv_wr_en = 1'b0;
   logic [15:0] adv_wr_data = '0;
   logic [15:0] adv_word;
   logic        rx_word_vld = 1'b0;
   logic [15:0] rx_word = '0;
   logic        idle10_det = 1'b0;
   logic        idle100_det = 1'b0;
   logic        restart = 1'b0;
   logic        an_done, an_fail, res_speed100, res_full;
   logic [15:0] lp_word;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   anar_core #(.TIMEOUT_CYC(200)) u_anar_core (
      .clk(clk), .rst_n(rst_n), .strap_tech(strap_tech),
      .adv_wr_en(adv_wr_en), .adv_wr_data(adv_wr_data), .adv_word(adv_word),
      .rx_word_vld(rx_word_vld), .rx_word(rx_word),
      .idle10_det(idle10_det), .idle100_det(idle100_det), .restart(restart),
      .an_done(an_done), .an_fail(an_fail), .res_speed100(res_speed100),
      .res_full(res_full), .lp_word(lp_word));

   // table: {adv ability 4b, partner ability 4b, exp fail, exp speed100, exp full}
   localparam int NV = 12;
   localparam logic [10:0] VEC [NV] = '{
      {4'b1111, 4'b1111, 3'b011}, {4'b1111, 4'b0111, 3'b010},
      {4'b1111, 4'b0011, 3'b001}, {4'b1111, 4'b0001, 3'b000},
      {4'b0111, 4'b1000, 3'b100}, {4'b0011, 4'b1100, 3'b100},
      {4'b0101, 4'b1111, 3'b010}, {4'b0011, 4'b1010, 3'b001},
      {4'b1010, 4'b0101, 3'b100}, {4'b1001, 4'b1001, 3'b011},
      {4'b1110, 4'b0110, 3'b010}, {4'b0001, 4'b0011, 3'b000}};

   function automatic logic [3:0] exp_seed(input logic [2:0] s);
      case (s)
         3'b111: return 4'b1111;
         3'b110: return 4'b1100;
         3'b101: return 4'b0011;
         3'b011: return 4'b0101;
         3'b010: return 4'b0100;
         3'b001: return 4'b0001;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic [15:0] mkword(input logic [3:0] ab, input logic ack);
      return {1'b0, ack, 5'b0, ab, 5'b00001};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] s);
      @(negedge clk);
      rst_n = 1'b0; strap_tech = s;
      rx_word_vld = 1'b0; idle10_det = 1'b0; idle100_det = 1'b0;
      restart = 1'b0; adv_wr_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input logic [15:0] w);
      rx_word = w; rx_word_vld = 1'b1;
      @(negedge clk);
      rx_word_vld = 1'b0;
   endtask

   task automatic pulse_restart();
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
   endtask

   task automatic wr_adv(input logic [15:0] d);
      adv_wr_data = d; adv_wr_en = 1'b1;
      @(negedge clk);
      adv_wr_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] wa, wb, wk;
      // R1: strap seeding
      for (int s = 0; s < 8; s++) begin
         do_reset(3'(s));
         chk($sformatf("R1 strap %0d", s), 32'(adv_word),
             32'({7'h0, exp_seed(3'(s)), 5'b00001}));
      end
      // reset state (R9 values)
      chk("R9 reset done/fail/spd/full", {an_done, an_fail, res_speed100, res_full}, 4'b0);
      chk("R9 reset lp_word", 32'(lp_word), 32'h0);

      // R2: clear-only ability
      do_reset(3'b001);
      wr_adv(16'hFFFF);
      chk("R2 write ones", 32'(adv_word), 32'hFE21);
      wr_adv(16'h0000);
      chk("R2 write zeros", 32'(adv_word), 32'h0001);

      // table walk: R5, R7
      for (int v = 0; v < NV; v++) begin
         logic [3:0] av, pv;
         av = VEC[v][10:7]; pv = VEC[v][6:3];
         do_reset(3'b111);
         wr_adv({7'h0, av, 5'h0});
         pulse_restart();
         repeat (3) send(mkword(pv, 1'b0));
         chk($sformatf("R3 vec %0d lp stored", v), 32'(lp_word), 32'(mkword(pv, 1'b0)));
         repeat (3) send(mkword(pv, 1'b1));
         chk($sformatf("R5 vec %0d fail/done/spd/full", v),
             {an_fail, an_done, res_speed100, res_full},
             {VEC[v][2], !VEC[v][2], VEC[v][1:0]});
         if (VEC[v][2]) begin
            chk($sformatf("R7 vec %0d lp cleared", v), 32'(lp_word), 32'h0);
            repeat (3) send(mkword(pv, 1'b0));
            chk($sformatf("R7 vec %0d relisten", v), 32'(lp_word), 32'(mkword(pv, 1'b0)));
         end
      end

      // R3: differing word restarts count
      do_reset(3'b111);
      pulse_restart();
      wa = mkword(4'b1111, 1'b0); wb = mkword(4'b0111, 1'b0);
      send(wa); send(wa); send(wb); send(wb);
      chk("R3 not yet stored", 32'(lp_word), 32'h0);
      send(wb);
      chk("R3 stored after restart of count", 32'(lp_word), 32'(wb));
      // R3: acknowledge bit ignored while listening
      pulse_restart();
      send(wa); send(wa | 16'h4000); send(wa);
      chk("R3 ack ignored", 32'(lp_word), 32'(wa));
      // R4: word without ack resets count
      wk = wa | 16'h4000;
      send(wk); send(wk); send(wa); send(wk); send(wk);
      chk("R4 not done after break", 32'(an_done), 32'h0);
      send(wk);
      chk("R4 done", {an_done, res_speed100, res_full}, 3'b111);
      // R10: ignore while done
      idle10_det = 1'b1;
      send(mkword(4'b0001, 1'b0));
      idle10_det = 1'b0;
      @(negedge clk);
      chk("R10 held", {an_done, res_speed100, res_full}, 3'b111);
      chk("R10 lp held", 32'(lp_word), 32'(wa));
      // R9
      pulse_restart();
      chk("R9 restart clears", {an_done, an_fail, res_speed100, res_full}, 4'b0);
      chk("R9 restart lp", 32'(lp_word), 32'h0);

      // R6: idles
      idle100_det = 1'b1; @(negedge clk); idle100_det = 1'b0;
      chk("R6 idle100", {an_done, res_speed100, res_full}, 3'b110);
      pulse_restart();
      idle10_det = 1'b1; @(negedge clk); idle10_det = 1'b0;
      chk("R6 idle10", {an_done, res_speed100, res_full}, 3'b100);
      pulse_restart();
      idle10_det = 1'b1; idle100_det = 1'b1; @(negedge clk);
      idle10_det = 1'b0; idle100_det = 1'b0;
      chk("R6 both idles", {an_done, res_speed100, res_full}, 3'b110);

      // R8: timeout
      pulse_restart();
      repeat (190) @(negedge clk);
      chk("R8 before timeout", {an_fail, an_done}, 2'b00);
      repeat (15) @(negedge clk);
      chk("R8 after timeout", {an_fail, an_done}, 2'b10);
      pulse_restart();
      chk("R9 restart clears fail", 32'(an_fail), 32'h0);

      finish_run();
   end
endmodule